// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the control logic for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It looks at the operation codes in decode, execute and memory, at the two source register IDs being decoded, at the load destination register in execute, and at the branch outcome from execute. From these it tells each pipeline register what to do at the next clock edge: load as usual, hold its contents, or load a no-op.

The outputs are purely combinational. The pipeline registers act on them at the start of the following cycle. Three conditions are detected:

- **Load/use hazard:** a load or pop in execute writes a register that decode is about to read.
- **Misprediction:** a conditional jump in execute turns out not taken.
- **Return in flight:** a return sits in decode, execute or memory.

When these coincide, a fixed priority settles them. The load/use hazard wins over the return's request to flush decode, so decode is never told to hold and flush in the same cycle.

Operation codes are parameters. Their defaults are load = 4'h5, pop = 4'hB, conditional jump = 4'h7 and return = 4'h9. Register ID 4'hF means "no register".

Top module: `hz_ctrl`

## Requirements
- R1: A load/use hazard exists when the execute code equals the load code (4'h5) or the pop code (4'hB), and `e_mem_dst` equals `d_src_a` or `d_src_b`. While it exists, `dec_hold` is 1, and `dec_hold` is 0 at all other times.
- R2: A `e_mem_dst` value of 4'hF never matches, even when a source ID is also 4'hF.
- R3: `fetch_hold` is 1 exactly when a load/use hazard exists, or when the return code (4'h9) appears in `d_op`, `e_op` or `m_op`.
- R4: `exe_flush` is 1 exactly when a load/use hazard exists, or when `e_op` is the jump code (4'h7) with `e_taken` at 0.
- R5: `dec_flush` is 1 exactly when there is a misprediction, or when a return is in decode, execute or memory with no load/use hazard present.
- R6: `dec_hold` and `dec_flush` are never both 1.
- R7: With no hazard present, all four outputs are 0. This includes the idle case with no-op codes (4'h1), and a jump in execute with `e_taken` at 1.
- R8: When a not-taken jump is in execute and a return is in decode, `fetch_hold`, `dec_flush` and `exe_flush` are 1 and `dec_hold` is 0.
- R9: When a load into register 4'h4 is in execute and a return reading register 4'h4 is in decode, `fetch_hold`, `dec_hold` and `exe_flush` are 1 and `dec_flush` is 0, so the return stays in decode one more cycle.
- R10: The outputs follow an input change within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_op | input | 4 | Operation code in decode |
| e_op | input | 4 | Operation code in execute |
| m_op | input | 4 | Operation code in memory |
| d_src_a | input | 4 | First source register ID in decode |
| d_src_b | input | 4 | Second source register ID in decode |
| e_mem_dst | input | 4 | Load destination register ID in execute |
| e_taken | input | 1 | Branch outcome from execute, 1 = taken |
| fetch_hold | output | 1 | Fetch register keeps its value |
| dec_hold | output | 1 | Decode register keeps its value |
| dec_flush | output | 1 | Decode register loads a no-op |
| exe_flush | output | 1 | Execute register loads a no-op |

## Verification
The hardest case to reach is the coincidence of a load/use hazard and a return. It needs a load or pop in execute, a return in decode, and a matching register ID, all in the same cycle. A uniformly random stimulus would almost never produce this. The bench therefore steers its random operation codes towards the four meaningful codes and draws register IDs from a set of four values that includes 4'hF, so matches, non-matches and the no-register case all occur often. Directed vectors cover both hazard combinations explicitly, and the random run adds many more overlaps.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef struct packed {
        logic fetch_hold;
        logic dec_hold;
        logic dec_flush;
        logic exe_flush;
    } hz_ctl_t;
endpackage

// File: rtl/hz_src_match.sv
// Compares one destination ID against every decode source ID.
module hz_src_match #(
    parameter int unsigned REG_W = 4,
    parameter int unsigned NSRC  = 2,
    parameter logic [REG_W-1:0] NOREG = '1
) (
    input  logic [REG_W-1:0]           dst,
    input  logic [NSRC-1:0][REG_W-1:0] srcs,
    output logic                       hit
);
    logic [NSRC-1:0] eq;

    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        assign eq[i] = (srcs[i] == dst);
    end

    // The "no register" ID never produces a match.
    assign hit = (dst != NOREG) && (|eq);
endmodule

// File: rtl/hz_op_seen.sv
// Reports whether a given operation code appears in any of the listed stages.
module hz_op_seen #(
    parameter int unsigned OP_W = 4,
    parameter int unsigned NSTG = 3,
    parameter logic [OP_W-1:0] CODE = '0
) (
    input  logic [NSTG-1:0][OP_W-1:0] ops,
    output logic                      seen
);
    logic [NSTG-1:0] at;

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
        assign at[s] = (ops[s] == CODE);
    end

    assign seen = |at;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
    parameter int unsigned OP_W  = 4,
    parameter int unsigned REG_W = 4,
    parameter logic [OP_W-1:0]  LOAD_OP = 'h5,
    parameter logic [OP_W-1:0]  POP_OP  = 'hB,
    parameter logic [OP_W-1:0]  JUMP_OP = 'h7,
    parameter logic [OP_W-1:0]  RET_OP  = 'h9,
    parameter logic [REG_W-1:0] NOREG   = 'hF
) (
    input  logic [OP_W-1:0]  d_op,
    input  logic [OP_W-1:0]  e_op,
    input  logic [OP_W-1:0]  m_op,
    input  logic [REG_W-1:0] d_src_a,
    input  logic [REG_W-1:0] d_src_b,
    input  logic [REG_W-1:0] e_mem_dst,
    input  logic             e_taken,
    output logic             fetch_hold,
    output logic             dec_hold,
    output logic             dec_flush,
    output logic             exe_flush
);
    import hz_pkg::*;

    localparam int unsigned NSRC = 2;  // decode source ports
    localparam int unsigned NSTG = 3;  // stages a return can occupy

    logic [NSRC-1:0][REG_W-1:0] srcs;
    logic [NSTG-1:0][OP_W-1:0]  ops;
    logic src_hit;
    logic ret_live;
    logic e_is_load;
    logic load_use;
    logic mispredict;
    hz_ctl_t ctl_d;

    assign srcs = {d_src_b, d_src_a};
    assign ops  = {m_op, e_op, d_op};

    hz_src_match #(
        .REG_W (REG_W),
        .NSRC  (NSRC),
        .NOREG (NOREG)
    ) u_match (
        .dst  (e_mem_dst),
        .srcs (srcs),
        .hit  (src_hit)
    );

    hz_op_seen #(
        .OP_W (OP_W),
        .NSTG (NSTG),
        .CODE (RET_OP)
    ) u_ret (
        .ops  (ops),
        .seen (ret_live)
    );

    assign e_is_load  = (e_op == LOAD_OP) || (e_op == POP_OP);
    assign load_use   = e_is_load && src_hit;
    assign mispredict = (e_op == JUMP_OP) && !e_taken;

    // Priority: a load/use hazard overrides the return's request to flush decode.
    always_comb begin
        ctl_d            = '0;
        ctl_d.fetch_hold = load_use || ret_live;
        ctl_d.dec_hold   = load_use;
        ctl_d.dec_flush  = mispredict || (ret_live && !load_use);
        ctl_d.exe_flush  = mispredict || load_use;
    end

    assign fetch_hold = ctl_d.fetch_hold;
    assign dec_hold   = ctl_d.dec_hold;
    assign dec_flush  = ctl_d.dec_flush;
    assign exe_flush  = ctl_d.exe_flush;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
    parameter int unsigned OP_W  = 4,
    parameter int unsigned REG_W = 4,
    parameter logic [OP_W-1:0]  JUMP_OP = 'h7,
    parameter logic [OP_W-1:0]  RET_OP  = 'h9,
    parameter logic [REG_W-1:0] NOREG   = 'hF
) (
    input logic [OP_W-1:0]  d_op,
    input logic [OP_W-1:0]  e_op,
    input logic [OP_W-1:0]  m_op,
    input logic [REG_W-1:0] e_mem_dst,
    input logic             e_taken,
    input logic             fetch_hold,
    input logic             dec_hold,
    input logic             dec_flush,
    input logic             exe_flush
);
    always_comb begin
        // R6
        hold_flush_excl_chk: assert (!(dec_hold && dec_flush))
            else $error("decode held and flushed together");
        // R1
        hold_side_chk: assert (!dec_hold || (fetch_hold && exe_flush))
            else $error("decode hold without fetch hold and execute flush");
        // R2
        noreg_chk: assert (!(e_mem_dst == NOREG && dec_hold))
            else $error("no-register ID raised a hazard");
        // R5
        ret_flush_chk: assert (!((d_op == RET_OP || e_op == RET_OP || m_op == RET_OP)
                                 && !dec_hold) || dec_flush)
            else $error("return in flight without decode flush");
        // R4
        exe_cause_chk: assert (!exe_flush || dec_hold || (e_op == JUMP_OP && !e_taken))
            else $error("execute flush without a cause");
    end
endmodule

bind hz_ctrl hz_ctrl_chk #(
    .OP_W    (OP_W),
    .REG_W   (REG_W),
    .JUMP_OP (JUMP_OP),
    .RET_OP  (RET_OP),
    .NOREG   (NOREG)
) u_chk (
    .d_op       (d_op),
    .e_op       (e_op),
    .m_op       (m_op),
    .e_mem_dst  (e_mem_dst),
    .e_taken    (e_taken),
    .fetch_hold (fetch_hold),
    .dec_hold   (dec_hold),
    .dec_flush  (dec_flush),
    .exe_flush  (exe_flush)
);

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;
    localparam logic [3:0] LD = 4'h5, PP = 4'hB, JX = 4'h7, RT = 4'h9, NP = 4'h1, NR = 4'hF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [3:0] d_op, e_op, m_op, d_src_a, d_src_b, e_mem_dst;
    logic e_taken;
    logic fetch_hold, dec_hold, dec_flush, exe_flush;

    int n_vec = 0;
    int n_bad = 0;

    hz_ctrl dut (
        .d_op(d_op), .e_op(e_op), .m_op(m_op),
        .d_src_a(d_src_a), .d_src_b(d_src_b), .e_mem_dst(e_mem_dst),
        .e_taken(e_taken),
        .fetch_hold(fetch_hold), .dec_hold(dec_hold),
        .dec_flush(dec_flush), .exe_flush(exe_flush)
    );

    // Expected {fetch_hold, dec_hold, dec_flush, exe_flush} from the requirements.
    function automatic logic [3:0] model(input logic [3:0] dop, eop, mop, sa, sb, dst,
                                         input logic tk);
        logic lu, rt, mp;
        lu = (eop == LD || eop == PP) && dst != NR && (dst == sa || dst == sb);
        rt = (dop == RT) || (eop == RT) || (mop == RT);
        mp = (eop == JX) && !tk;
        return {lu || rt, lu, mp || (rt && !lu), mp || lu};
    endfunction

    task automatic drive(input logic [3:0] dop, eop, mop, sa, sb, dst, input logic tk);
        d_op = dop; e_op = eop; m_op = mop;
        d_src_a = sa; d_src_b = sb; e_mem_dst = dst; e_taken = tk;
    endtask

    task automatic check(input string tag);
        logic [3:0] exp, got;
        exp = model(d_op, e_op, m_op, d_src_a, d_src_b, e_mem_dst, e_taken);
        got = {fetch_hold, dec_hold, dec_flush, exe_flush};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (fh,dh,df,ef) ops d=%h e=%h m=%h src=%h/%h dst=%h tk=%b",
                     tag, got, exp, d_op, e_op, m_op, d_src_a, d_src_b, e_mem_dst, e_taken);
        end
    endtask

    task automatic expect_bits(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {fetch_hold, dec_hold, dec_flush, exe_flush};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (fh,dh,df,ef)", tag, got, exp);
        end
    endtask

    task automatic vec(input string tag, input logic [3:0] dop, eop, mop, sa, sb, dst,
                       input logic tk);
        @(negedge clk);
        drive(dop, eop, mop, sa, sb, dst, tk);
        #1;
        check(tag);
    endtask

    function automatic logic [3:0] pick_op();
        case ($urandom % 6)
            0: return LD;
            1: return PP;
            2: return JX;
            3: return RT;
            4: return NP;
            default: return 4'($urandom);
        endcase
    endfunction

    function automatic logic [3:0] pick_reg();
        case ($urandom % 4)
            0: return 4'h0;
            1: return 4'h3;
            2: return 4'h4;
            default: return NR;
        endcase
    endfunction

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        drive(NP, NP, NP, NR, NR, NR, 1'b1);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R7: idle state
        expect_bits("R7 idle", 4'b0000);

        vec("R1 load hits src_a", NP, LD, NP, 4'h3, 4'h0, 4'h3, 1'b1);
        expect_bits("R1 load hits src_a", 4'b1101);
        vec("R1 pop hits src_b", NP, PP, NP, 4'h0, 4'h4, 4'h4, 1'b1);
        expect_bits("R1 pop hits src_b", 4'b1101);
        vec("R1 load no match", NP, LD, NP, 4'h0, 4'h3, 4'h4, 1'b1);
        expect_bits("R1 load no match", 4'b0000);
        vec("R2 noreg vs noreg", NP, LD, NP, NR, NR, NR, 1'b1);
        expect_bits("R2 noreg vs noreg", 4'b0000);
        vec("R3 ret in memory", NP, NP, RT, NR, NR, NR, 1'b1);
        expect_bits("R3 ret in memory", 4'b1010);
        vec("R3 ret in execute", NP, RT, NP, NR, NR, NR, 1'b1);
        expect_bits("R3 ret in execute", 4'b1010);
        vec("R4 mispredict", NP, JX, NP, NR, NR, NR, 1'b0);
        expect_bits("R4 mispredict", 4'b0011);
        vec("R7 taken jump", NP, JX, NP, NR, NR, NR, 1'b1);
        expect_bits("R7 taken jump", 4'b0000);
        vec("R8 mispredict with ret in decode", RT, JX, NP, NR, NR, NR, 1'b0);
        expect_bits("R8 mispredict with ret in decode", 4'b1011);
        vec("R9 load sp then ret", RT, LD, NP, 4'h4, 4'h4, 4'h4, 1'b1);
        expect_bits("R9 load sp then ret", 4'b1101);
        vec("R5 ret in memory under load/use", NP, PP, RT, 4'h3, NR, 4'h3, 1'b1);
        expect_bits("R5 ret in memory under load/use", 4'b1101);

        // R10: a mid-cycle change shows up without any clock edge.
        @(posedge clk);
        #1;
        drive(NP, NP, NP, NR, NR, NR, 1'b1);
        #1;
        expect_bits("R10 settle low", 4'b0000);
        drive(NP, JX, NP, NR, NR, NR, 1'b0);
        #1;
        expect_bits("R10 same-cycle response", 4'b0011);

        // R1 R3 R4 R5 R6: random mix
        for (int i = 0; i < 3000; i++) begin
            vec("R1/R3/R4/R5/R6 random", pick_op(), pick_op(), pick_op(),
                pick_reg(), pick_reg(), pick_reg(), 1'($urandom));
            // R6
            n_vec++;
            if (dec_hold && dec_flush) begin
                n_bad++;
                $display("FAIL R6: got hold=1 flush=1 expected not both");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule